// File: doc/BRIEF.md
# Interprocessor interrupt command register

This block is the command register pair that a processor core writes to raise an interrupt on another core, or on a group of cores. It sits on a 32-bit register port. One word holds the target core number. The other word holds the interrupt vector, the delivery kind, a level bit and a destination shorthand. The second word is also the trigger. A write to it launches a message toward the interrupt interconnect, and the message is carried on a valid/ready handshake.

While that message waits for the interconnect, a read-only pending bit in the command word reads 1. Software polls this bit before it starts another send. It also polls it after the send, to learn that the message has left. A command write that arrives while a message is still pending is dropped. A shorthand selects self, all cores, or all cores except the sender. When a shorthand is chosen, the target number is not used and the outgoing destination is driven to zero.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset both words read 0 and `msgValid` is 0.
- R2: Registers are whole 32-bit words. The command word is at offset `LOW_OFF` (default 0x00) and the target word at `HIGH_OFF` (default 0x10). A write to any other address, including one that is not 16-byte aligned, changes nothing, and a read of any other address returns 0.
- R3: The target word keeps the core number in bits 31:24 and reads 0 in bits 23:0. Writing it alone never raises `msgValid`.
- R4: A command-word write while nothing is pending raises `msgValid` from the next cycle. The message carries the written fields and the target number held at that moment.
- R5: Command word layout: vector 7:0; delivery kind 10:8 (000 fixed, 010 SMI, 101 INIT, 110 start-up); level 14; shorthand 19:18. Every other bit reads 0. The written fields read back unchanged.
- R6: Bit 12 of the command word reads 1 while a message is pending and 0 once it is accepted. Writing bit 12 has no effect.
- R7: While `msgValid` is 1 and `msgReady` is 0, the message stays stable. When `msgReady` is sampled 1 with `msgValid`, `msgValid` and the pending bit are 0 from the next cycle.
- R8: A command-word write while a message is pending is dropped. Both the message and the command-word readback stay as they were.
- R9: A target-word write while a message is pending updates the target readback but not `msgDest`.
- R10: For a shorthand other than 00 (01 self, 10 all, 11 all except sender), `msgDest` is 0 whatever the target word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Write strobe for one register word |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| msgValid | output | 1 | Message pending toward the interconnect |
| msgReady | input | 1 | Interconnect accepts the message |
| msgDest | output | 8 | Target core number, 0 when a shorthand is used |
| msgVector | output | 8 | Interrupt vector |
| msgMode | output | 3 | Delivery kind |
| msgLevel | output | 1 | Level bit |
| msgShorthand | output | 2 | Destination shorthand |

## Verification
The bench targets the launch boundary in three ways.

It writes the target word while a message is in flight. A design that read the target live instead of capturing it would change `msgDest` under a stalled handshake. It also writes a second command while the first is pending. A design that did not drop that write would overwrite the pending message, or would launch twice.

It stalls `msgReady` for several cycles and then pulses it for one cycle. A design with the pending flag off by one cycle would clear too early or lose the message. Command writes carry every reserved bit and the pending bit set, and a shorthand is paired with a nonzero target. A design that stored raw write data, or forwarded the target under a shorthand, would show nonzero reserved bits or a wrong `msgDest`.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

  localparam int REG_W    = 32;
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int STAT_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int SH_LSB   = 18;
  localparam int DEST_LSB = 24;
  localparam int DEST_W   = 8;

  // command fields held by the register and carried in the message
  typedef struct packed {
    logic [1:0] shorthand;
    logic       level;
    logic [2:0] mode;
    logic [7:0] vector;
  } ipiCmdT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrHigh;
    logic launch;
  } ipiStrbT;

endpackage

// File: rtl/ipi_cmd_ctrl.sv
module ipi_cmd_ctrl
  import ipi_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgReady,
  output ipiStrbT           strb,
  output logic              busy
);

  logic hitLow;
  logic hitHigh;
  logic accept;

  // exact address match: unaligned addresses never decode
  assign hitLow  = regWrite && (regAddr == LOW_OFF);
  assign hitHigh = regWrite && (regAddr == HIGH_OFF);
  assign accept  = busy && msgReady;

  always_comb begin
    strb        = '0;
    strb.wrHigh = hitHigh;
    strb.launch = hitLow && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b0;
    end else if (strb.launch) begin
      busy <= 1'b1;
    end
  end

endmodule

// File: rtl/ipi_cmd_dpath.sv
module ipi_cmd_dpath
  import ipi_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipiStrbT           strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [DEST_W-1:0] msgDest,
  output ipiCmdT            msgCmd
);

  logic [DEST_W-1:0] targetQ;
  logic [DEST_W-1:0] destQ;
  ipiCmdT            cmdQ;
  ipiCmdT            cmdIn;
  logic              unusedWdata;

  assign cmdIn.vector    = regWdata[VEC_LSB +: 8];
  assign cmdIn.mode      = regWdata[MODE_LSB +: 3];
  assign cmdIn.level     = regWdata[LVL_BIT];
  assign cmdIn.shorthand = regWdata[SH_LSB +: 2];

  // reserved and read-only bits of the write data are dropped
  assign unusedWdata = ^{regWdata[23:20], regWdata[17:15], regWdata[13:11]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '0;
      destQ   <= '0;
      cmdQ    <= '0;
    end else begin
      if (strb.wrHigh) begin
        targetQ <= regWdata[DEST_LSB +: DEST_W];
      end
      if (strb.launch) begin
        cmdQ  <= cmdIn;
        destQ <= (cmdIn.shorthand != 2'b00) ? '0 : targetQ;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == LOW_OFF) begin
      regRdata[VEC_LSB +: 8]  = cmdQ.vector;
      regRdata[MODE_LSB +: 3] = cmdQ.mode;
      regRdata[STAT_BIT]      = busy;
      regRdata[LVL_BIT]       = cmdQ.level;
      regRdata[SH_LSB +: 2]   = cmdQ.shorthand;
    end else if (regAddr == HIGH_OFF) begin
      regRdata[DEST_LSB +: DEST_W] = targetQ;
    end
  end

  assign msgDest = destQ;
  assign msgCmd  = cmdQ;

endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [7:0]        msgDest,
  output logic [7:0]        msgVector,
  output logic [2:0]        msgMode,
  output logic              msgLevel,
  output logic [1:0]        msgShorthand
);

  ipiStrbT strb;
  logic    busy;
  ipiCmdT  msgCmd;

  ipi_cmd_ctrl #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .msgReady (msgReady),
    .strb     (strb),
    .busy     (busy)
  );

  ipi_cmd_dpath #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busy     (busy),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .msgDest  (msgDest),
    .msgCmd   (msgCmd)
  );

  assign msgValid     = busy;
  assign msgVector    = msgCmd.vector;
  assign msgMode      = msgCmd.mode;
  assign msgLevel     = msgCmd.level;
  assign msgShorthand = msgCmd.shorthand;

endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 'h00,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic              msgValid,
  input logic              msgReady,
  input logic [7:0]        msgDest,
  input logic [7:0]        msgVector,
  input logic [2:0]        msgMode,
  input logic              msgLevel,
  input logic [1:0]        msgShorthand
);

  localparam logic [31:0] LOW_DEFINED = 32'h000C_57FF;

  AST_LAUNCH_RAISES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == LOW_OFF && !msgValid) |=> msgValid); // R4

  AST_HIGH_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == HIGH_OFF && !msgValid) |=> !msgValid); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=>
      (msgValid && $stable({msgDest, msgVector, msgMode, msgLevel, msgShorthand}))); // R7

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid); // R7

  AST_SHORTHAND_NO_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShorthand != 2'b00) |-> (msgDest == 8'h00)); // R10

  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == LOW_OFF) |-> (regRdata[12] == msgValid)); // R6

  AST_LOW_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == LOW_OFF) |-> ((regRdata & ~LOW_DEFINED) == 32'h0)); // R5

  AST_HIGH_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == HIGH_OFF) |-> (regRdata[23:0] == 24'h0)); // R3

endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .regWrite     (regWrite),
  .regAddr      (regAddr),
  .regRdata     (regRdata),
  .msgValid     (msgValid),
  .msgReady     (msgReady),
  .msgDest      (msgDest),
  .msgVector    (msgVector),
  .msgMode      (msgMode),
  .msgLevel     (msgLevel),
  .msgShorthand (msgShorthand)
);

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOW_A  = 8'h00;
  localparam logic [7:0] HIGH_A = 8'h10;
  localparam logic [31:0] JUNK  = 32'hFFF3_B800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgDest;
  logic [7:0]  msgVector;
  logic [2:0]  msgMode;
  logic        msgLevel;
  logic [1:0]  msgShorthand;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [21:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_reg dut_i (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .msgValid(msgValid),
    .msgReady(msgReady), .msgDest(msgDest), .msgVector(msgVector),
    .msgMode(msgMode), .msgLevel(msgLevel), .msgShorthand(msgShorthand)
  );

  function automatic logic [31:0] mkLo(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic lvl, input logic [1:0] sh);
    return 32'(vec) | (32'(mode) << 8) | (32'(lvl) << 14) | (32'(sh) << 18);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0; regWdata = 32'h0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    check(regRdata == exp, req, regRdata, exp);
  endtask

  // driver side: launch a command and record the message it must produce
  task automatic send(input logic [7:0] target, input logic [7:0] vec, input logic [2:0] mode,
                      input logic lvl, input logic [1:0] sh);
    expQ.push_back({(sh != 2'b00) ? 8'h00 : target, vec, mode, lvl, sh});
    wr(LOW_A, mkLo(vec, mode, lvl, sh) | JUNK);
  endtask

  // monitor: on every accepted handshake compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rstN && msgValid && msgReady) begin
        logic [21:0] got;
        logic [21:0] exp;
        got = {msgDest, msgVector, msgMode, msgLevel, msgShorthand};
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected message", 32'(got), 32'h0);
        end else begin
          exp = expQ.pop_front();
          check(got == exp, "R4/R10 message content", 32'(got), 32'(exp));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk(LOW_A, 32'h0, "R1 low after reset");
    rdChk(HIGH_A, 32'h0, "R1 high after reset");
    check(msgValid == 1'b0, "R1 valid after reset", 32'(msgValid), 32'h0);

    // R3 target word alone sends nothing
    wr(HIGH_A, 32'hAB00_FFFF);
    rdChk(HIGH_A, 32'hAB00_0000, "R3 target readback");
    check(msgValid == 1'b0, "R3 no send on target write", 32'(msgValid), 32'h0);

    // R2 unaligned and unmapped addresses
    wr(8'h14, 32'h7700_0000);
    wr(8'h01, mkLo(8'h11, 3'b000, 1'b1, 2'b00));
    rdChk(HIGH_A, 32'hAB00_0000, "R2 unaligned write ignored");
    check(msgValid == 1'b0, "R2 unaligned write no send", 32'(msgValid), 32'h0);
    rdChk(8'h04, 32'h0, "R2 unaligned read zero");
    rdChk(8'h20, 32'h0, "R2 unmapped read zero");

    // R4 R5 R6 launch, fixed mode, ready stalled
    send(8'hAB, 8'h31, 3'b000, 1'b1, 2'b00);
    check(msgValid == 1'b1, "R4 valid after launch", 32'(msgValid), 32'h1);
    rdChk(LOW_A, mkLo(8'h31, 3'b000, 1'b1, 2'b00) | 32'h1000, "R5 R6 low readback pending");

    // R7 stable under stall, R8 dropped write, R9 target change
    repeat (3) @(negedge clk);
    check(msgVector == 8'h31 && msgValid, "R7 held under stall", 32'(msgVector), 32'h31);
    wr(LOW_A, mkLo(8'h77, 3'b101, 1'b0, 2'b11));
    rdChk(LOW_A, mkLo(8'h31, 3'b000, 1'b1, 2'b00) | 32'h1000, "R8 pending write dropped");
    check(msgVector == 8'h31 && msgMode == 3'b000, "R8 message unchanged", 32'(msgVector), 32'h31);
    wr(HIGH_A, 32'h5500_0000);
    rdChk(HIGH_A, 32'h5500_0000, "R9 target readback updated");
    check(msgDest == 8'hAB, "R9 msgDest held", 32'(msgDest), 32'hAB);

    // R7 one-cycle ready pulse
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
    #1;
    check(msgValid == 1'b0, "R7 valid clears after accept", 32'(msgValid), 32'h0);
    rdChk(LOW_A, mkLo(8'h31, 3'b000, 1'b1, 2'b00), "R6 pending bit clear");

    // R10 shorthand all-except-sender, INIT, ready held high
    msgReady = 1'b1;
    send(8'h55, 8'h00, 3'b101, 1'b1, 2'b11);
    #1;
    check(msgValid == 1'b1 && msgDest == 8'h00, "R10 dest zero under shorthand", 32'(msgDest), 32'h0);
    @(negedge clk); #1;
    check(msgValid == 1'b0, "R7 accepted in one cycle", 32'(msgValid), 32'h0);

    // start-up to target, then SMI to all
    send(8'h55, 8'h9A, 3'b110, 1'b1, 2'b00);
    @(negedge clk);
    send(8'h55, 8'h42, 3'b010, 1'b1, 2'b10);
    repeat (2) @(negedge clk);
    msgReady = 1'b0;
    check(expQ.size() == 0, "R4 all messages delivered", 32'(expQ.size()), 32'h0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule